// File: doc/BRIEF.md
# Address-Shared Serial Word Link

This block carries an N-bit parallel word across one serial data wire. At the sending end a multiplexer puts one bit of the word on the wire. At the receiving end a demultiplexer routes that bit back into its place in an output register. Both ends are steered by the same binary address bus. A sequencer steps the address through the bit positions once per enabled clock, so a word uses log2(N) address wires plus one data wire between the two ends.

The sequencer is a small state machine with three states. `SEQ_LOAD` is the state at address 0, where the input word is latched. `SEQ_SEND` covers the middle addresses. `SEQ_LAST` is the state at address N-1. The named transitions are:

- `load_to_send`: enabled, leaving address 0 (goes straight to `SEQ_LAST` when N is 2).
- `send_to_last`: enabled, at address N-2.
- `last_to_load`: enabled, wrapping from N-1 to 0.
- `hold`: enable low, in any state.

Reset puts the machine in `SEQ_LOAD`. While enable is low, the wire is driven to 0 and nothing advances, so several senders can share the line through an OR.

Top module: `addr_serial_link`

## Requirements
- R1: After synchronous active-high reset, the address bus is 0, the parallel output is all zeros and the word strobe is 0.
- R2: Each clock edge with enable high advances the address by one, wrapping from N-1 to 0. N is a power of two (default 8) and the address bus is log2(N) bits wide.
- R3: While enable is low, the address holds, the serial line is 0 and the parallel output does not change.
- R4: With enable high, the serial line carries bit number `addr` of the word being sent. At address 0 this is bit 0 of the live input word.
- R5: The input word is latched on the enabled edge taken at address 0. Changes to the input during the rest of that sweep do not affect the bits sent.
- R6: On each enabled edge, the serial bit is stored into output position `addr` only; all other output positions keep their values.
- R7: The word strobe is high for exactly the one cycle after the enabled edge that stores position N-1. During that cycle the parallel output equals the word latched at the start of that sweep.
- R8: The receive write-select lines are one-hot decoded from the address (address k selects only position k) and are all inactive while enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable: advances the sweep and gates the serial line |
| par_in | input | N | Parallel word to send |
| ser_line | output | 1 | Serial data wire between the two ends |
| addr_bus | output | log2(N) | Shared bit-position address |
| par_out | output | N | Reassembled parallel word |
| word_done | output | 1 | One-cycle strobe after a full word is stored |

## Verification
A sequencer state that is out of step with the counter shows on `word_done` as a strobe that is missing or in the wrong cycle, within one sweep of N enabled clocks. A wrong address decode or a wrong holding-register value shows on `ser_line` in the same cycle. It also shows in `par_out` on the very next edge, because the bench tracks which positions a partially received word must already hold. A pause that leaks shows within one cycle as a moving `addr_bus`, a nonzero line, or a changed output bit.

// File: rtl/link_pkg.sv
package link_pkg;
    typedef enum logic [1:0] {
        SEQ_LOAD = 2'd0,
        SEQ_SEND = 2'd1,
        SEQ_LAST = 2'd2
    } seq_state_t;
endpackage

// File: rtl/link_sequencer.sv
module link_sequencer
    import link_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [AW-1:0] addr,
    output logic          capture,
    output logic          at_last
);
    localparam logic [AW-1:0] ADDR_PENULT = AW'(N - 2);

    seq_state_t    state_q, state_d;
    logic [AW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_LOAD;
        else     state_q <= state_d;
    end

    // address counter
    always_ff @(posedge clk) begin
        if (rst)     cnt_q <= '0;
        else if (en) cnt_q <= (state_q == SEQ_LAST) ? '0 : cnt_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_LOAD: if (en) state_d = (N == 2) ? SEQ_LAST : SEQ_SEND;  // load_to_send
            SEQ_SEND: if (en && cnt_q == ADDR_PENULT) state_d = SEQ_LAST; // send_to_last
            SEQ_LAST: if (en) state_d = SEQ_LOAD;                         // last_to_load
            default:  state_d = SEQ_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        addr    = cnt_q;
        capture = en && (state_q == SEQ_LOAD);
        at_last = (state_q == SEQ_LAST);
    end
endmodule

// File: rtl/link_tx_mux.sv
module link_tx_mux #(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          capture,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  par_in,
    output logic          ser
);
    logic [N-1:0] hold_q;
    logic [N-1:0] src_word;
    logic [N-1:0] pick;

    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (capture) hold_q <= par_in;
    end

    // at address 0 the live word is sent, later positions come from the latch
    assign src_word = (addr == '0) ? par_in : hold_q;

    for (genvar i = 0; i < N; i++) begin : g_sel
        assign pick[i] = (addr == AW'(i)) & src_word[i];
    end

    assign ser = en & (|pick);
endmodule

// File: rtl/link_rx_demux.sv
module link_rx_demux #(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          at_last,
    input  logic [AW-1:0] addr,
    input  logic          ser,
    output logic [N-1:0]  wr_sel,
    output logic [N-1:0]  par_out,
    output logic          word_done
);
    for (genvar i = 0; i < N; i++) begin : g_pos
        assign wr_sel[i] = en && (addr == AW'(i));

        always_ff @(posedge clk) begin
            if (rst)            par_out[i] <= 1'b0;
            else if (wr_sel[i]) par_out[i] <= ser;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) word_done <= 1'b0;
        else     word_done <= en && at_last;
    end
endmodule

// File: rtl/addr_serial_link.sv
module addr_serial_link #(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [N-1:0]  par_in,
    output logic          ser_line,
    output logic [AW-1:0] addr_bus,
    output logic [N-1:0]  par_out,
    output logic          word_done
);
    logic          capture;
    logic          at_last;
    logic [N-1:0]  rx_sel;

    link_sequencer #(.N(N), .AW(AW)) u_seq (
        .clk(clk), .rst(rst), .en(en),
        .addr(addr_bus), .capture(capture), .at_last(at_last)
    );

    link_tx_mux #(.N(N), .AW(AW)) u_tx (
        .clk(clk), .rst(rst), .en(en), .capture(capture),
        .addr(addr_bus), .par_in(par_in), .ser(ser_line)
    );

    link_rx_demux #(.N(N), .AW(AW)) u_rx (
        .clk(clk), .rst(rst), .en(en), .at_last(at_last),
        .addr(addr_bus), .ser(ser_line), .wr_sel(rx_sel),
        .par_out(par_out), .word_done(word_done)
    );
endmodule

// File: rtl/addr_serial_link_chk.sv
module addr_serial_link_chk #(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          ser_line,
    input logic [AW-1:0] addr_bus,
    input logic [N-1:0]  par_out,
    input logic          word_done,
    input logic [N-1:0]  rx_sel
);
    localparam logic [AW-1:0] ADDR_TOP = AW'(N - 1);

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (en && addr_bus == ADDR_TOP) |=> (addr_bus == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && addr_bus != ADDR_TOP) |=> (addr_bus == $past(addr_bus) + 1'b1));

    assert_line_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !en |-> !ser_line);

    assert_pause_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(addr_bus) && $stable(par_out)));

    assert_store_R6: assert property (@(posedge clk) disable iff (rst)
        en |=> (par_out[$past(addr_bus)] == $past(ser_line)));

    assert_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        word_done |-> ($past(addr_bus) == ADDR_TOP && $past(en)));

    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rx_sel) && (en == (rx_sel != '0)));
endmodule

bind addr_serial_link addr_serial_link_chk #(.N(N), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .en(en), .ser_line(ser_line),
    .addr_bus(addr_bus), .par_out(par_out), .word_done(word_done),
    .rx_sel(rx_sel)
);

// File: tb/addr_serial_link_bench.sv
module addr_serial_link_bench;
    localparam int N  = 8;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [N-1:0]  par_in = '0;
    logic          ser_line;
    logic [AW-1:0] addr_bus;
    logic [N-1:0]  par_out;
    logic          word_done;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] model_out = '0;

    always #2.5 clk = ~clk;

    addr_serial_link #(.N(N), .AW(AW)) u_addr_serial_link (
        .clk(clk), .rst(rst), .en(en), .par_in(par_in),
        .ser_line(ser_line), .addr_bus(addr_bus),
        .par_out(par_out), .word_done(word_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one enabled bit slot: inputs set after negedge, comb outputs checked, then edge
    task automatic send_slot(input logic [N-1:0] word, input int pos, input logic scramble);
        @(negedge clk);
        en = 1'b1;
        par_in = (pos == 0 || !scramble) ? word : ~word;
        #1;
        check("R2 addr", 32'(addr_bus), 32'(pos));
        check("R4 R5 serial bit", 32'(ser_line), 32'(word[pos]));
        check("R6 R8 partial output", 32'(par_out), 32'(model_out));
        if (pos != 0) check("R7 no early strobe", 32'(word_done), 32'd0);
        @(posedge clk);
        model_out[pos] = word[pos];
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1 addr", 32'(addr_bus), 32'd0);
        check("R1 par_out", 32'(par_out), 32'd0);
        check("R1 strobe", 32'(word_done), 32'd0);
        model_out = '0;
    endtask

    task automatic t_word(input logic [N-1:0] word, input logic scramble);
        for (int p = 0; p < N; p++) send_slot(word, p, scramble);
        @(negedge clk);
        en = 1'b0;
        #1;
        check("R7 strobe", 32'(word_done), 32'd1);
        check("R7 word out", 32'(par_out), 32'(word));
        check("R2 wrap", 32'(addr_bus), 32'd0);
        @(negedge clk);
        #1;
        check("R7 strobe one cycle", 32'(word_done), 32'd0);
    endtask

    task automatic t_pause(input logic [N-1:0] word);
        for (int p = 0; p < 3; p++) send_slot(word, p, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            en = 1'b0; par_in = $urandom;
            #1;
            check("R3 line low", 32'(ser_line), 32'd0);
            check("R3 addr held", 32'(addr_bus), 32'd3);
            check("R3 out held", 32'(par_out), 32'(model_out));
        end
        for (int p = 3; p < N; p++) send_slot(word, p, 1'b1);
        @(negedge clk);
        en = 1'b0;
        #1;
        check("R7 strobe after pause", 32'(word_done), 32'd1);
        check("R5 R7 word after pause", 32'(par_out), 32'(word));
    endtask

    task automatic t_back_to_back(input logic [N-1:0] w1, input logic [N-1:0] w2);
        for (int p = 0; p < N; p++) send_slot(w1, p, 1'b0);
        // first slot of w2 overlaps w1 strobe
        @(negedge clk);
        en = 1'b1; par_in = w2;
        #1;
        check("R7 strobe back to back", 32'(word_done), 32'd1);
        check("R7 word back to back", 32'(par_out), 32'(w1));
        @(posedge clk);
        model_out[0] = w2[0];
        for (int p = 1; p < N; p++) send_slot(w2, p, 1'b1);
        @(negedge clk);
        en = 1'b0;
        #1;
        check("R7 second word", 32'(par_out), 32'(w2));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        t_reset();
        t_word(8'hA5, 1'b1);
        t_word(8'hFF, 1'b0);
        t_word(8'h00, 1'b1);
        for (int r = 0; r < 6; r++) begin
            t_word(N'($urandom), 1'b1);
            @(negedge clk); en = 1'b0;
        end
        t_pause(8'h3C);
        t_back_to_back(8'h81, 8'h7E);
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule